// File: doc/BRIEF.md
# Dual Selectable Data Pointer

This block holds two 16-bit address pointers that share one architectural name. A one-bit select register decides which of the two is live. The live pointer drives the address bus of an external data memory controller. Core increment and whole-word load operations touch only the live pointer. A block-copy loop loads a source address into one pointer and a destination into the other, then flips the select bit once per transfer.

The processor core reaches all five registers over an 8-bit special-function-register bus. This bus carries a decoded address, a write strobe with data, and a read strobe. The block returns read data combinationally on the same cycle. The select register keeps only its lowest bit, so read-increment-write on it alternates the two pointers.

Top module: `dual_dptr`

## Requirements
- R1: After a synchronous active-low reset, both pointers and the select bit are 0, so `mem_addr` is 0000h and `sel_out` is 0.
- R2: An SFR write to 82h or 83h replaces the low or high byte of pointer 0, and a write to 84h or 85h does the same for pointer 1. The other byte is left unchanged. A read of each of these addresses returns the stored byte on the same cycle.
- R3: The select register at 86h stores only bit 0, which is visible on `sel_out`. A read of 86h returns bit 0 in bit 0 and zeros in bits 7:1, whatever was written.
- R4: `mem_addr` equals pointer 0 when the select bit is 0 and pointer 1 when it is 1. It holds steady in any cycle with no write, load or increment.
- R5: `ptr_inc` adds 1 to the selected pointer at the next clock edge. The carry passes from the low byte into the high byte, and FFFFh wraps to 0000h.
- R6: `ptr_load` replaces the selected pointer with `ptr_load_val` at the next clock edge. When `ptr_load` and `ptr_inc` are both asserted, the load wins.
- R7: An increment or load leaves the pointer that is not selected unchanged.
- R8: An SFR byte write to the selected pointer in the same cycle as a core increment or load has priority. The written byte takes the bus data, and the other byte of that pointer keeps its old value. The core operation is dropped for that cycle.
- R9: Writing a value to 86h sets the select bit to bit 0 of that value, with effect from the next cycle. So writing back the read value plus one toggles the live pointer.
- R10: `sfr_rdata` is 00h whenever `sfr_rd` is low or the address is outside 82h–86h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_rdata | output | 8 | SFR read data, 00h when not addressed |
| ptr_inc | input | 1 | Increment the selected pointer |
| ptr_load | input | 1 | Load the selected pointer with ptr_load_val |
| ptr_load_val | input | 16 | Value for a pointer load |
| mem_addr | output | 16 | Selected pointer, used as data memory address |
| sel_out | output | 1 | Current select bit |

## Verification
The checker examines a few rules on every clock cycle:
- the zero upper bits of a select read;
- idle read data;
- the one-step advance of the live address after a lone increment;
- the exact value after a lone load;
- the select bit following a write to 86h;
- the address holding still when nothing happens.

Some behaviour is only visible through the bench's scenarios, because a stateless property cannot see the hidden pointer:
- that the unselected pointer survives increments and loads;
- that a colliding SFR write keeps the other byte and drops the core operation;
- the FFFFh wrap.

The bench reads both pointers back over the SFR bus against its own model to show these.

// File: rtl/dptr_pkg.sv
// Package: shared sizes and address layout for the dual data pointer.
// Assumes an 8-bit SFR data bus and pointers of two bytes each.
package dptr_pkg;
    localparam int SFR_DW   = 8;
    localparam int SFR_AW   = 8;
    localparam int PTR_BYTES = 2;
    localparam logic [SFR_AW-1:0] DEF_BASE = 8'h82;
endpackage

// File: rtl/dptr_decode.sv
// Module: dptr_decode
// Decodes an SFR address into per-pointer low/high byte hits and a select hit.
// Assumes pointer i occupies BASE+2i (low) and BASE+2i+1 (high); select follows.
module dptr_decode #(
    parameter int                       NUM_PTR = 2,
    parameter int                       AW      = dptr_pkg::SFR_AW,
    parameter logic [AW-1:0]            BASE    = dptr_pkg::DEF_BASE
) (
    input  logic [AW-1:0]      addr,
    output logic [NUM_PTR-1:0] lo_hit,
    output logic [NUM_PTR-1:0] hi_hit,
    output logic               sel_hit
);
    localparam logic [AW-1:0] SEL_ADDR = BASE + AW'(2 * NUM_PTR);

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_dec
        localparam logic [AW-1:0] LO_ADDR = BASE + AW'(2 * i);
        localparam logic [AW-1:0] HI_ADDR = BASE + AW'(2 * i + 1);
        // Compare the address with this pointer's two byte locations.
        assign lo_hit[i] = (addr == LO_ADDR);
        assign hi_hit[i] = (addr == HI_ADDR);
    end

    // Compare the address with the select register location.
    assign sel_hit = (addr == SEL_ADDR);
endmodule

// File: rtl/dptr_reg.sv
// Module: dptr_reg
// One pointer register with byte writes, whole-word load and increment.
// Assumes a byte write outranks load, and load outranks increment.
module dptr_reg #(
    parameter int BW = dptr_pkg::SFR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wdata,
    input  logic          op_inc,
    input  logic          op_load,
    input  logic [2*BW-1:0] load_val,
    output logic [2*BW-1:0] value
);
    localparam int PW = 2 * BW;

    logic [PW-1:0] q;

    // Update the pointer by priority: SFR byte write, then load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) q[BW-1:0]    <= wdata;
            if (wr_hi) q[PW-1:BW]   <= wdata;
        end else if (op_load) begin
            q <= load_val;
        end else if (op_inc) begin
            q <= q + PW'(1);
        end
    end

    assign value = q;
endmodule

// File: rtl/dptr_select.sv
// Module: dptr_select
// Select register that keeps only its low SW bits of any written byte.
// Assumes the write strobe is already qualified by the address decode.
module dptr_select #(
    parameter int SW = 1,
    parameter int BW = dptr_pkg::SFR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [BW-1:0] wdata,
    output logic [SW-1:0] sel
);
    // Capture the low select bits on a write; the rest of the byte is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)  sel <= '0;
        else if (wr) sel <= wdata[SW-1:0];
    end
endmodule

// File: rtl/dual_dptr.sv
// Module: dual_dptr
// Two data pointers behind one select register on an SFR bus; the chosen
// pointer drives mem_addr and receives core increment/load operations.
// Assumes decoded single-cycle strobes and combinational read data.
module dual_dptr #(
    parameter int                          NUM_PTR = 2,
    parameter int                          BW      = dptr_pkg::SFR_DW,
    parameter int                          AW      = dptr_pkg::SFR_AW,
    parameter logic [AW-1:0]               BASE    = dptr_pkg::DEF_BASE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        sfr_addr,
    input  logic                 sfr_wr,
    input  logic [BW-1:0]        sfr_wdata,
    input  logic                 sfr_rd,
    output logic [BW-1:0]        sfr_rdata,
    input  logic                 ptr_inc,
    input  logic                 ptr_load,
    input  logic [2*BW-1:0]      ptr_load_val,
    output logic [2*BW-1:0]      mem_addr,
    output logic                 sel_out
);
    localparam int PW = dptr_pkg::PTR_BYTES * BW;
    localparam int SW = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

    logic [NUM_PTR-1:0] lo_hit, hi_hit;
    logic               sel_hit;
    logic [SW-1:0]      sel_q;
    logic [PW-1:0]      ptr_q [NUM_PTR];

    dptr_decode #(.NUM_PTR(NUM_PTR), .AW(AW), .BASE(BASE)) u_dec (
        .addr    (sfr_addr),
        .lo_hit  (lo_hit),
        .hi_hit  (hi_hit),
        .sel_hit (sel_hit)
    );

    dptr_select #(.SW(SW), .BW(BW)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (sfr_wr && sel_hit),
        .wdata (sfr_wdata),
        .sel   (sel_q)
    );

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        logic active;
        // Route core operations only to the pointer the select bits name.
        assign active = (sel_q == SW'(i));
        dptr_reg #(.BW(BW)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (sfr_wr && lo_hit[i]),
            .wr_hi    (sfr_wr && hi_hit[i]),
            .wdata    (sfr_wdata),
            .op_inc   (ptr_inc && active),
            .op_load  (ptr_load && active),
            .load_val (ptr_load_val),
            .value    (ptr_q[i])
        );
    end

    // Return the addressed byte during a read strobe, else zero.
    always_comb begin
        sfr_rdata = '0;
        if (sfr_rd) begin
            for (int i = 0; i < NUM_PTR; i++) begin
                if (lo_hit[i]) sfr_rdata = ptr_q[i][BW-1:0];
                if (hi_hit[i]) sfr_rdata = ptr_q[i][PW-1:BW];
            end
            if (sel_hit) sfr_rdata = BW'(sel_q);
        end
    end

    assign mem_addr = ptr_q[sel_q];
    assign sel_out  = sel_q[0];
endmodule

// File: rtl/dual_dptr_chk.sv
// Module: dual_dptr_chk
// Cycle-level properties of dual_dptr seen at its ports; bound below.
// Assumes the default two-pointer layout with the select register after them.
module dual_dptr_chk #(
    parameter int             NUM_PTR = 2,
    parameter int             BW      = 8,
    parameter int             AW      = 8,
    parameter logic [AW-1:0]  BASE    = 8'h82
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   sfr_addr,
    input logic            sfr_wr,
    input logic [BW-1:0]   sfr_wdata,
    input logic            sfr_rd,
    input logic [BW-1:0]   sfr_rdata,
    input logic            ptr_inc,
    input logic            ptr_load,
    input logic [2*BW-1:0] ptr_load_val,
    input logic [2*BW-1:0] mem_addr,
    input logic            sel_out
);
    localparam logic [AW-1:0] SEL_ADDR = BASE + AW'(2 * NUM_PTR);

    AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && sfr_addr == SEL_ADDR) |-> (sfr_rdata[BW-1:1] == '0)); // R3
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_rd |-> (sfr_rdata == '0)); // R10
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ptr_load && !sfr_wr) |=> (mem_addr == $past(mem_addr) + 16'd1)); // R5
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && !sfr_wr) |=> (mem_addr == $past(ptr_load_val))); // R6
    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == SEL_ADDR) |=> (sel_out == $past(sfr_wdata[0]))); // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_inc && !ptr_load && !sfr_wr) |=> ($stable(mem_addr) && $stable(sel_out))); // R4
endmodule

bind dual_dptr dual_dptr_chk #(
    .NUM_PTR(NUM_PTR), .BW(BW), .AW(AW), .BASE(BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
    .ptr_inc(ptr_inc), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .mem_addr(mem_addr), .sel_out(sel_out)
);

// File: tb/sim_dual_dptr.sv
`timescale 1ns/1ps
// Bench for dual_dptr: directed corners plus seeded random traffic checked
// against a behavioural model kept in bench variables.
module sim_dual_dptr;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  sfr_addr;
    logic        sfr_wr;
    logic [7:0]  sfr_wdata;
    logic        sfr_rd;
    logic [7:0]  sfr_rdata;
    logic        ptr_inc;
    logic        ptr_load;
    logic [15:0] ptr_load_val;
    logic [15:0] mem_addr;
    logic        sel_out;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] m0, m1;
    logic        msel;

    always #10 clk = ~clk;

    dual_dptr u0 (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
        .ptr_inc(ptr_inc), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
        .mem_addr(mem_addr), .sel_out(sel_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a, input logic r);
        if (!r) return 8'h00;
        case (a)
            8'h82: return m0[7:0];
            8'h83: return m0[15:8];
            8'h84: return m1[7:0];
            8'h85: return m1[15:8];
            8'h86: return {7'b0, msel};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_req(input logic [7:0] a, input logic r);
        if (r && a == 8'h86) return "R3";
        if (r && a >= 8'h82 && a <= 8'h85) return "R2";
        return "R10";
    endfunction

    function automatic logic [15:0] next_ptr(input logic [15:0] p, input logic [7:0] lo_a,
                                             input logic is_sel, input logic [7:0] a,
                                             input logic w, input logic [7:0] d,
                                             input logic inc, input logic ld,
                                             input logic [15:0] lv);
        logic [15:0] r;
        r = p;
        if (w && (a == lo_a || a == lo_a + 8'd1)) begin
            if (a == lo_a) r[7:0]  = d;
            else           r[15:8] = d;
        end else if (is_sel && ld) begin
            r = lv;
        end else if (is_sel && inc) begin
            r = p + 16'd1;
        end
        return r;
    endfunction

    // One cycle: drive at negedge, check current state, update model after edge.
    task automatic apply(input logic [7:0] a, input logic w, input logic [7:0] d,
                         input logic r, input logic inc, input logic ld,
                         input logic [15:0] lv);
        logic [15:0] n0, n1;
        @(negedge clk);
        sfr_addr = a; sfr_wr = w; sfr_wdata = d; sfr_rd = r;
        ptr_inc = inc; ptr_load = ld; ptr_load_val = lv;
        #2;
        check("R4", mem_addr, msel ? m1 : m0);
        check("R9", sel_out, msel);
        check(rd_req(a, r), sfr_rdata, exp_rd(a, r));
        @(posedge clk);
        #1;
        n0 = next_ptr(m0, 8'h82, !msel, a, w, d, inc, ld, lv);
        n1 = next_ptr(m1, 8'h84, msel, a, w, d, inc, ld, lv);
        m0 = n0; m1 = n1;
        if (w && a == 8'h86) msel = d[0];
        sfr_wr = 1'b0; sfr_rd = 1'b0; ptr_inc = 1'b0; ptr_load = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        apply(a, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0000);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        apply(a, 1'b1, d, 1'b0, 1'b0, 1'b0, 16'h0000);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] v;
        rst_n = 1'b0; sfr_addr = '0; sfr_wr = 0; sfr_wdata = '0; sfr_rd = 0;
        ptr_inc = 0; ptr_load = 0; ptr_load_val = '0;
        m0 = '0; m1 = '0; msel = 1'b0;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2;
        // R1: reset state
        check("R1", mem_addr, 16'h0000);
        check("R1", sel_out, 1'b0);
        rd(8'h82); rd(8'h85); rd(8'h86);

        // R2: byte writes and read-back
        wr(8'h82, 8'h34); wr(8'h83, 8'h12); wr(8'h84, 8'hCD); wr(8'h85, 8'hAB);
        rd(8'h82); rd(8'h83); rd(8'h84); rd(8'h85);
        check("R2", m0, 16'h1234); check("R2", m1, 16'hABCD);

        // R3 / R9: only bit 0 kept
        wr(8'h86, 8'hFE); rd(8'h86);
        check("R3", msel, 1'b0);
        wr(8'h86, 8'hFF); rd(8'h86);
        check("R9", mem_addr, 16'hABCD);
        // R9: read, add one, write back toggles
        v = sfr_rdata;
        wr(8'h86, 8'h01 + 8'h01); rd(8'h86);
        check("R9", sel_out, 1'b0);

        // R5 / R7: wrap of pointer 0, pointer 1 untouched
        wr(8'h82, 8'hFF); wr(8'h83, 8'hFF);
        apply(8'h00, 0, 0, 0, 1'b1, 1'b0, 16'h0);
        rd(8'h82);
        check("R5", mem_addr, 16'h0000);
        rd(8'h84); rd(8'h85);
        check("R7", m1, 16'hABCD);
        // R5: carry into high byte
        wr(8'h82, 8'hFF);
        apply(8'h00, 0, 0, 0, 1'b1, 1'b0, 16'h0);
        rd(8'h83);

        // R6: load beats increment, on pointer 1
        wr(8'h86, 8'h01);
        apply(8'h00, 0, 0, 0, 1'b1, 1'b1, 16'h5A5A);
        rd(8'h84);
        check("R6", m1, 16'h5A5A);
        rd(8'h82); rd(8'h83);   // R7: pointer 0 kept across load

        // R8: SFR write collides with increment on selected pointer
        apply(8'h85, 1'b1, 8'h77, 1'b0, 1'b1, 1'b0, 16'h0);
        rd(8'h84); rd(8'h85);
        check("R8", m1, 16'h775A);
        apply(8'h84, 1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 16'hFFFF);
        rd(8'h84); rd(8'h85);
        check("R8", m1, 16'h7711);

        // R10: unmapped addresses and read strobe low
        rd(8'h81); rd(8'h87);
        apply(8'h84, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0);

        // Random traffic against the model
        for (int k = 0; k < 600; k++) begin
            logic [7:0] a;
            a = 8'h81 + 8'($urandom % 7);
            apply(a, ($urandom % 3) == 0, 8'($urandom), ($urandom % 2) == 0,
                  ($urandom % 2) == 0, ($urandom % 5) == 0, 16'($urandom));
        end
        for (int k = 0; k < 5; k++) rd(8'h82 + 8'(k));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule